// File: doc/BRIEF.md
# Video Timing Generator

This block generates the raster timing for a display interface from a pixel clock. Horizontal timing is set by a line length, a sync pulse width and an inclusive column window. All vertical timing is given as absolute pixel-clock counts from the start of the frame: the frame period, the vertical sync width, and the first and last counts of the display window. Because the vertical quantities are compared against one linear counter per frame, the display window can open and close partway through a line by a programmable skew.

A simple write port loads the settings. Timing settings go into a staging copy and become active only at a frame boundary, so a frame never mixes two configurations. The engine stays idle, with all outputs low, until its run bit is set. It restarts from count zero each time it is enabled.

Pixels arrive on a valid/ready stream. The block asserts ready during every display-enable cycle and consumes a beat only in those cycles, so it never applies back-pressure inside the window. If no beat is valid in a window cycle, the block outputs the fill colour instead and flags the underflow. Outside the window it takes no data and drives zero.

Top module: `vtg_engine`

## Requirements
- R1: In reset, hsync, vsync, de, pix_ready and underflow are low, pix_out is zero, the engine is stopped and the fill colour is 0x0000FF.
- R2: The register addresses are: 0 horizontal control ([31:16] line length, [15:0] hsync width), 1 horizontal window ([31:16] last column, [15:0] first column), 2 frame period, 3 vsync width, 4 display start count, 5 display end count, 6 fill colour (low PIX_W bits), 7 run (bit 0). Timing values are in pixel clocks.
- R3: The column counter h counts from 0 and wraps to 0 after line length − 1. hsync is high exactly when h < hsync width.
- R4: The frame counter f counts from 0 and wraps to 0 after frame period − 1. At that wrap h also returns to 0. vsync is high exactly when f < vsync width.
- R5: de is high exactly when first column ≤ h ≤ last column and display start ≤ f ≤ display end. All bounds are inclusive.
- R6: While the run bit is 0, every output is low. In the first cycle after 1 is written to the run bit, h = 0 and f = 0. Writing 0 stops the engine at once.
- R7: pix_ready equals de. In a de cycle with pix_valid high, pix_out = pix_in. In a de cycle with pix_valid low, pix_out = fill colour and underflow is high. Outside de, pix_out is 0 and underflow is low.
- R8: Writes to registers 0 to 5 take effect at the next frame wrap, or at once while the engine is stopped. Writes to the fill colour and the run bit take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel stream beat valid |
| pix_in | input | PIX_W | Pixel stream data |
| pix_ready | output | 1 | Pixel stream ready (equals de) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| pix_out | output | PIX_W | Pixel driven to the panel |
| underflow | output | 1 | Fill colour substituted this cycle |

## Verification
The assertions assume that a running configuration has a non-zero line length and a frame period that is a whole multiple of it. They also assume the window bounds fit inside those periods. Every configuration the bench loads meets these conditions. The bench covers every cycle of whole frames in two geometries: a skewed window in one, and a change of geometry written in the middle of a running frame in the other. It also drives pix_valid in a repeating gap pattern, so that both delivered and missing beats land inside the window.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int HCNT_W = 16;
  localparam int FCNT_W = 32;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_HCTL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_HWIN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FPER   = 3'd2;
  localparam logic [ADDR_W-1:0] A_VSW    = 3'd3;
  localparam logic [ADDR_W-1:0] A_VSTART = 3'd4;
  localparam logic [ADDR_W-1:0] A_VEND   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FILL   = 3'd6;
  localparam logic [ADDR_W-1:0] A_RUN    = 3'd7;

  typedef struct packed {
    logic [HCNT_W-1:0] hlen;
    logic [HCNT_W-1:0] hpw;
    logic [HCNT_W-1:0] hlast;
    logic [HCNT_W-1:0] hfirst;
    logic [FCNT_W-1:0] fper;
    logic [FCNT_W-1:0] vsw;
    logic [FCNT_W-1:0] vfirst;
    logic [FCNT_W-1:0] vlast;
  } vtg_timing_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              load,
  output vtg_timing_t       active,
  output logic [PIX_W-1:0]  fill,
  output logic              run
);
  localparam logic [PIX_W-1:0] FILL_RST = PIX_W'(8'hFF);

  vtg_timing_t staged;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      fill   <= FILL_RST;
      run    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_HCTL:   begin
          staged.hlen <= wr_data[31:16];
          staged.hpw  <= wr_data[15:0];
        end
        A_HWIN:   begin
          staged.hlast  <= wr_data[31:16];
          staged.hfirst <= wr_data[15:0];
        end
        A_FPER:   staged.fper   <= wr_data;
        A_VSW:    staged.vsw    <= wr_data;
        A_VSTART: staged.vfirst <= wr_data;
        A_VEND:   staged.vlast  <= wr_data;
        A_FILL:   fill          <= wr_data[PIX_W-1:0];
        default:  run           <= wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) active <= '0;
    else if (load) active <= staged;
  end
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  logic [W-1:0] last;

  always_comb begin
    last    = (limit == '0) ? '0 : limit - W'(1);
    at_last = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (restart || at_last) cnt <= '0;
    else cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              run,
  input  vtg_timing_t       t,
  input  logic [HCNT_W-1:0] h,
  input  logic [FCNT_W-1:0] f,
  input  logic [PIX_W-1:0]  fill,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              pix_ready,
  output logic [PIX_W-1:0]  pix_out,
  output logic              underflow
);
  logic in_cols, in_rows;

  always_comb begin
    in_cols   = (h >= t.hfirst) && (h <= t.hlast);
    in_rows   = (f >= t.vfirst) && (f <= t.vlast);
    hsync     = run && (h < t.hpw);
    vsync     = run && (f < t.vsw);
    de        = run && in_cols && in_rows;
    pix_ready = de;
    underflow = de && !pix_valid;
    if (!de) pix_out = '0;
    else if (pix_valid) pix_out = pix_in;
    else pix_out = fill;
  end
endmodule

// File: rtl/vtg_engine.sv
module vtg_engine
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              pix_ready,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix_out,
  output logic              underflow
);
  vtg_timing_t       active;
  logic [PIX_W-1:0]  fill;
  logic              run;
  logic [HCNT_W-1:0] hcnt;
  logic [FCNT_W-1:0] fcnt;
  logic              h_last, f_last, frame_wrap;

  assign frame_wrap = run && f_last;

  vtg_regs #(.PIX_W(PIX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(frame_wrap || !run), .active(active), .fill(fill), .run(run)
  );

  vtg_counter #(.W(HCNT_W)) u_hcnt (
    .clk(clk), .rst(rst), .run(run), .restart(frame_wrap),
    .limit(active.hlen), .cnt(hcnt), .at_last(h_last)
  );

  vtg_counter #(.W(FCNT_W)) u_fcnt (
    .clk(clk), .rst(rst), .run(run), .restart(1'b0),
    .limit(active.fper), .cnt(fcnt), .at_last(f_last)
  );

  vtg_window #(.PIX_W(PIX_W)) u_win (
    .run(run), .t(active), .h(hcnt), .f(fcnt), .fill(fill),
    .pix_valid(pix_valid), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_ready(pix_ready),
    .pix_out(pix_out), .underflow(underflow)
  );
endmodule

// File: rtl/vtg_engine_checker.sv
module vtg_engine_checker
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              frame_wrap,
  input vtg_timing_t       active,
  input logic [HCNT_W-1:0] hcnt,
  input logic [FCNT_W-1:0] fcnt,
  input logic [PIX_W-1:0]  fill,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic              underflow,
  input logic [PIX_W-1:0]  pix_out
);
  // R3: column counter stays inside the line
  a_r3_col_in_line: assert property (@(posedge clk) disable iff (rst)
    (run && active.hlen != '0) |-> (hcnt < active.hlen));

  // R4: frame counter stays inside the frame
  a_r4_count_in_frame: assert property (@(posedge clk) disable iff (rst)
    (run && active.fper != '0) |-> (fcnt < active.fper));

  // R6: stopped engine is silent
  a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!hsync && !vsync && !de));

  // R6: restart from zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (hcnt == '0 && fcnt == '0));

  // R8: active timing only changes at a frame wrap or while stopped
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_wrap) |=> $stable(active));

  // R7: underflow substitutes the fill colour
  a_r7_fill_on_gap: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (pix_out == fill));

  // R7: nothing leaves outside the window
  a_r7_zero_outside: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix_out == '0 && !underflow));
endmodule

bind vtg_engine vtg_engine_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .frame_wrap(frame_wrap), .active(active),
  .hcnt(hcnt), .fcnt(fcnt), .fill(fill), .hsync(hsync), .vsync(vsync),
  .de(de), .underflow(underflow), .pix_out(pix_out)
);

// File: tb/vtg_engine_bench.sv
module vtg_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic pix_ready, hsync, vsync, de, underflow;
  logic [PIX_W-1:0] pix_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_engine #(.PIX_W(PIX_W)) u_vtg_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .pix_in(pix_in), .pix_ready(pix_ready),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .underflow(underflow)
  );

  // geometry A: hlen 10, hpw 2, cols 3..7, 6 lines, vsw 1 line, skew 3
  // geometry B: hlen 8, hpw 1, cols 2..6, 5 lines, vsw 1 line, no skew
  int g_hlen[2]  = '{10, 8};
  int g_hpw[2]   = '{2, 1};
  int g_hf[2]    = '{3, 2};
  int g_hl[2]    = '{7, 6};
  int g_fper[2]  = '{60, 40};
  int g_vsw[2]   = '{10, 8};
  int g_vf[2]    = '{23, 16};
  int g_vl[2]    = '{52, 31};
  logic [PIX_W-1:0] exp_fill = 24'h0000FF;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic load_geo(int g);
    wr(3'd0, {g_hlen[g][15:0], g_hpw[g][15:0]});
    wr(3'd1, {g_hl[g][15:0], g_hf[g][15:0]});
    wr(3'd2, g_fper[g]);
    wr(3'd3, g_vsw[g]);
    wr(3'd4, g_vf[g]);
    wr(3'd5, g_vl[g]);
  endtask

  // check one cycle at position t of geometry g
  task automatic check_at(int g, int t);
    int f, h;
    logic e_hs, e_vs, e_de;
    f = t % g_fper[g];
    h = f % g_hlen[g];
    e_hs = h < g_hpw[g];
    e_vs = f < g_vsw[g];
    e_de = (h >= g_hf[g]) && (h <= g_hl[g]) && (f >= g_vf[g]) && (f <= g_vl[g]);
    pix_valid = (t % 3) != 0;
    pix_in = PIX_W'(32'hA00000 + t);
    #1;
    chk("R3 hsync", hsync, e_hs);
    chk("R4 vsync", vsync, e_vs);
    chk("R5 de", de, e_de);
    chk("R7 ready", pix_ready, e_de);
    chk("R7 underflow", underflow, e_de && !pix_valid);
    chk("R7 pixel", pix_out, !e_de ? 0 : (pix_valid ? pix_in : exp_fill));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 hsync", hsync, 0);
    chk("R1 vsync", vsync, 0);
    chk("R1 de", de, 0);
    chk("R1 pix", pix_out, 0);
    rst = 1'b0;

    // R2 R8: load while stopped, outputs stay low (R6)
    load_geo(0);
    @(negedge clk);
    chk("R6 stopped hsync", hsync, 0);
    chk("R6 stopped vsync", vsync, 0);

    // R6: enable, R1 default fill 0xFF used on underflow
    wr(3'd7, 1);
    for (int t = 0; t < 130; t++) begin
      @(negedge clk);
      check_at(0, t);
    end

    // R6: stop takes effect at once
    wr(3'd7, 0);
    @(negedge clk); #1;
    chk("R6 off hsync", hsync, 0);
    chk("R6 off de", de, 0);

    // R8: fill colour immediate
    wr(3'd6, 32'h00123456);
    exp_fill = 24'h123456;

    // restart with A, write B mid-frame
    wr(3'd7, 1);
    fork
      begin
        for (int t = 0; t < 60 + 90; t++) begin
          @(negedge clk);
          if (t < 60) check_at(0, t);
          else check_at(1, t - 60);
        end
      end
      begin
        repeat (4) @(posedge clk);
        load_geo(1);
      end
    join

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule